// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the command front end of a byte-wide flash memory whose address space is cut into sixteen equal erase blocks. A host issues command bytes through a single-cycle write strobe carrying an address and a data byte. The controller decodes them, runs two-cycle erase, byte-program and lock-bit sequences, and lets a running erase or program be paused and later continued. It also keeps a status byte with a ready flag, suspend flags and error flags that stay set until they are cleared on purpose.

The storage array lives outside the block. The controller presents one array address. While an operation runs, that address is the operation's target; otherwise it is the host read address. The controller takes back the byte stored there. When an operation finishes, it raises a one-cycle write or block-erase pulse. Erase and program durations are parameterised cycle counts. The read data port returns array data, the status byte or identification bytes, depending on the selected read mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `ready` is 1, the read mode is array, no block is locked, and the status byte reads 80h.
- R2: Writing 20h and then D0h, both at an address in the target block, erases that block to FFh after exactly ERASE_CYC cycles. `ready` stays 0 during those cycles, and no other block changes.
- R3: Writing 40h and then an address/data pair programs that byte after exactly PROG_CYC busy cycles. The stored value becomes the old byte ANDed with the new data.
- R4: Writing FFh selects array reads, 70h selects status reads and 90h selects identification reads. In identification mode, read address offset 0 returns MFG_ID, offset 1 returns DEV_ID, offset 2 returns the lock bit of the addressed block in bit 0, and offset 3 returns 0. The offset is the low two address bits. Every setup, second-cycle, suspend or resume write switches the mode to status.
- R5: The status byte holds these fields: bit 7 ready, bit 6 erase suspended, bit 5 erase/sequence error, bit 4 program/sequence error, bit 3 supply error, bit 2 program suspended, bit 1 protection error, bit 0 always 0.
- R6: After a 20h or 60h setup, a second byte that is not a valid confirm sets status bits 5 and 4 and starts nothing.
- R7: Status bits 5, 4, 3 and 1 only clear on a 50h write (or reset). Later successful operations and mode changes leave them set.
- R8: B0h during a running erase or program stops it. `ready` is 1 on the next cycle, the matching suspend flag is set, and the remaining count is kept. D0h continues from that count. A B0h that arrives in the final busy cycle has no effect, and the operation completes.
- R9: While an erase is suspended, a byte program to another block runs to completion and the erase stays suspended. A program into the suspended block sets bits 5 and 4 instead.
- R10: A program that runs during erase suspend can itself be suspended, which sets both suspend flags. The first D0h continues the program and a later D0h continues the erase.
- R11: Writing 60h then 01h locks the addressed block, and 60h then D0h unlocks all blocks. A program or erase aimed at a locked block sets status bit 1 and changes nothing. 20h and 60h are ignored while anything is suspended, and 40h is ignored while a program is suspended.
- R12: If `vpp_ok` is 0 on a program or erase confirm write, status bit 3 is set, `ready` stays 1, and the array is untouched.
- R13: While an operation runs, every write other than B0h is ignored, including read-mode, clear and setup bytes.
- R14: `ready` equals status bit 7 and falls only in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address latched with each write |
| wr_data | input | 8 | Command or program data byte |
| vpp_ok | input | 1 | Programming supply is in range |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Array, status or identification byte |
| ready | output | 1 | 1 when no operation is running |
| mem_addr | output | ADDR_W | Array address (operation target while busy, else rd_addr) |
| arr_data | input | 8 | Array byte at mem_addr |
| mem_we | output | 1 | One-cycle byte write at program completion |
| mem_wdata | output | 8 | Byte to store (old AND new) |
| mem_erase | output | 1 | One-cycle erase of the block holding mem_addr |

## Verification
The bench builds the block with ADDR_W=12, so sixteen 256-byte blocks fit in a small bench RAM. It uses ERASE_CYC=40 and PROG_CYC=6. These short durations allow exact busy-window checks, a suspend placed in mid-erase, a suspend timed into the last program cycle, and a program nested inside a suspended erase, each within a few hundred cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ESET,
        ST_PSET,
        ST_LSET,
        ST_ERUN,
        ST_PRUN
    } fc_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_IDENT
    } fc_rmode_e;

    // sticky error flags
    typedef struct packed {
        logic ers;
        logic prg;
        logic vpp;
        logic prot;
    } fc_err_t;

    localparam logic [7:0] OP_READ    = 8'hFF;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_PROG    = 8'h40;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;
    localparam logic [7:0] OP_LOCKSET = 8'h01;

endpackage

// File: rtl/fc_lock_bank.sv
module fc_lock_bank #(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_all,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [BLK_W-1:0] id_blk,
    output logic             wr_locked,
    output logic             id_locked
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] lock_w;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (clr_all)
                bit_q <= 1'b0;
            else if (set_en && wr_blk == BLK_W'(b))
                bit_q <= 1'b1;
        end
        assign lock_w[b] = bit_q;
    end

    assign wr_locked = lock_w[wr_blk];
    assign id_locked = lock_w[id_blk];
endmodule

// File: rtl/fc_read_mux.sv
module fc_read_mux
    import flash_cmd_pkg::*;
#(
    parameter logic [7:0] MFG_ID = 8'h5A,
    parameter logic [7:0] DEV_ID = 8'hA6
) (
    input  fc_rmode_e  rmode,
    input  logic [7:0] status,
    input  logic [7:0] arr_data,
    input  logic [1:0] id_sel,
    input  logic       id_locked,
    output logic [7:0] dout
);
    logic [7:0] id_byte;

    always_comb begin
        case (id_sel)
            2'd0:    id_byte = MFG_ID;
            2'd1:    id_byte = DEV_ID;
            2'd2:    id_byte = {7'd0, id_locked};
            default: id_byte = 8'h00;
        endcase
    end

    always_comb begin
        case (rmode)
            RM_STATUS: dout = status;
            RM_IDENT:  dout = id_byte;
            default:   dout = arr_data;
        endcase
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W    = 20,
    parameter int         BLK_W     = 4,
    parameter int         ERASE_CYC = 2000,
    parameter int         PROG_CYC  = 16,
    parameter logic [7:0] MFG_ID    = 8'h5A,
    parameter logic [7:0] DEV_ID    = 8'hA6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        arr_data,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_erase
);
    localparam int ECW = $clog2(ERASE_CYC + 1);
    localparam int PCW = $clog2(PROG_CYC + 1);

    typedef struct packed {
        fc_state_e         st;
        fc_rmode_e         rmode;
        logic              esusp;
        logic              psusp;
        fc_err_t           err;
        logic [ADDR_W-1:0] e_addr;
        logic [ADDR_W-1:0] p_addr;
        logic [7:0]        p_data;
        logic [ECW-1:0]    e_cnt;
        logic [PCW-1:0]    p_cnt;
    } ctl_t;

    ctl_t r_d, r_q;
    logic lock_set, lock_clr, wr_locked, id_locked;
    logic esusp_w, psusp_w;
    logic [3:0] sticky_w;
    logic [7:0] status;
    logic [BLK_W-1:0] wr_blk;

    assign wr_blk = wr_addr[ADDR_W-1 -: BLK_W];

    always_comb begin
        r_d      = r_q;
        lock_set = 1'b0;
        lock_clr = 1'b0;
        case (r_q.st)
            ST_IDLE: if (wr_en) begin
                case (wr_data)
                    OP_READ:   r_d.rmode = RM_ARRAY;
                    OP_STATUS: r_d.rmode = RM_STATUS;
                    OP_IDENT:  r_d.rmode = RM_IDENT;
                    OP_CLEAR:  r_d.err   = '0;
                    OP_ERASE: if (!r_q.esusp && !r_q.psusp) begin
                        r_d.st    = ST_ESET;
                        r_d.rmode = RM_STATUS;
                    end
                    OP_LOCK: if (!r_q.esusp && !r_q.psusp) begin
                        r_d.st    = ST_LSET;
                        r_d.rmode = RM_STATUS;
                    end
                    OP_PROG: if (!r_q.psusp) begin
                        r_d.st    = ST_PSET;
                        r_d.rmode = RM_STATUS;
                    end
                    OP_CONFIRM: begin
                        if (r_q.psusp) begin
                            r_d.psusp = 1'b0;
                            r_d.st    = ST_PRUN;
                            r_d.rmode = RM_STATUS;
                        end else if (r_q.esusp) begin
                            r_d.esusp = 1'b0;
                            r_d.st    = ST_ERUN;
                            r_d.rmode = RM_STATUS;
                        end
                    end
                    default: ;
                endcase
            end
            ST_ESET: if (wr_en) begin
                r_d.st = ST_IDLE;
                if (wr_data != OP_CONFIRM) begin
                    r_d.err.ers = 1'b1;
                    r_d.err.prg = 1'b1;
                end else if (wr_locked) begin
                    r_d.err.prot = 1'b1;
                end else if (!vpp_ok) begin
                    r_d.err.vpp = 1'b1;
                end else begin
                    r_d.e_addr = wr_addr;
                    r_d.e_cnt  = ECW'(ERASE_CYC);
                    r_d.st     = ST_ERUN;
                end
            end
            ST_PSET: if (wr_en) begin
                r_d.st = ST_IDLE;
                if (r_q.esusp && wr_blk == r_q.e_addr[ADDR_W-1 -: BLK_W]) begin
                    r_d.err.ers = 1'b1;
                    r_d.err.prg = 1'b1;
                end else if (wr_locked) begin
                    r_d.err.prot = 1'b1;
                end else if (!vpp_ok) begin
                    r_d.err.vpp = 1'b1;
                end else begin
                    r_d.p_addr = wr_addr;
                    r_d.p_data = wr_data;
                    r_d.p_cnt  = PCW'(PROG_CYC);
                    r_d.st     = ST_PRUN;
                end
            end
            ST_LSET: if (wr_en) begin
                r_d.st = ST_IDLE;
                if (wr_data == OP_LOCKSET) begin
                    lock_set = 1'b1;
                end else if (wr_data == OP_CONFIRM) begin
                    lock_clr = 1'b1;
                end else begin
                    r_d.err.ers = 1'b1;
                    r_d.err.prg = 1'b1;
                end
            end
            ST_ERUN: begin
                if (r_q.e_cnt == ECW'(1)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.e_cnt = r_q.e_cnt - 1'b1;
                    if (wr_en && wr_data == OP_SUSPEND) begin
                        r_d.esusp = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            ST_PRUN: begin
                if (r_q.p_cnt == PCW'(1)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.p_cnt = r_q.p_cnt - 1'b1;
                    if (wr_en && wr_data == OP_SUSPEND) begin
                        r_d.psusp = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.rmode <= RM_ARRAY;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.st != ST_ERUN) && (r_q.st != ST_PRUN);
    assign mem_erase = (r_q.st == ST_ERUN) && (r_q.e_cnt == ECW'(1));
    assign mem_we    = (r_q.st == ST_PRUN) && (r_q.p_cnt == PCW'(1));
    assign mem_wdata = r_q.p_data & arr_data;
    assign mem_addr  = (r_q.st == ST_ERUN) ? r_q.e_addr :
                       (r_q.st == ST_PRUN) ? r_q.p_addr : rd_addr;

    assign esusp_w  = r_q.esusp;
    assign psusp_w  = r_q.psusp;
    assign sticky_w = r_q.err;
    assign status   = {ready, esusp_w, sticky_w[3], sticky_w[2],
                       sticky_w[1], psusp_w, sticky_w[0], 1'b0};

    fc_lock_bank #(.BLK_W(BLK_W)) u_locks (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (lock_set),
        .clr_all  (lock_clr),
        .wr_blk   (wr_blk),
        .id_blk   (rd_addr[ADDR_W-1 -: BLK_W]),
        .wr_locked(wr_locked),
        .id_locked(id_locked)
    );

    fc_read_mux #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_rmux (
        .rmode    (r_q.rmode),
        .status   (status),
        .arr_data (arr_data),
        .id_sel   (rd_addr[1:0]),
        .id_locked(id_locked),
        .dout     (rd_data)
    );
endmodule

// File: rtl/fc_checker.sv
module fc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ready,
    input logic       mem_we,
    input logic       mem_erase,
    input logic [3:0] sticky,
    input logic       esusp,
    input logic       psusp
);
    a_r14_ready_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wr_en));

    a_r2_erase_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase |-> !ready);

    a_r3_prog_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ready);

    a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_erase) |=> ready);

    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && wr_data == 8'h50) |-> ((sticky & $past(sticky)) == $past(sticky)));

    a_r10_psusp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        psusp |-> ready);

    a_r8_no_erase_when_susp: assert property (@(posedge clk) disable iff (!rst_n)
        esusp |-> !mem_erase);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_erase));
endmodule

bind flash_cmd_ctrl fc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ready    (ready),
    .mem_we   (mem_we),
    .mem_erase(mem_erase),
    .sticky   (sticky_w),
    .esusp    (esusp_w),
    .psusp    (psusp_w)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    localparam int AW = 12;
    localparam int EC = 40;
    localparam int PC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          vpp_ok = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data, mem_wdata, arr_data;
    logic          ready, mem_we, mem_erase;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem [0:(1<<AW)-1];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .BLK_W(4), .ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vpp_ok(vpp_ok), .rd_addr(rd_addr),
        .rd_data(rd_data), .ready(ready), .mem_addr(mem_addr),
        .arr_data(arr_data), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_erase(mem_erase)
    );

    assign arr_data = mem[mem_addr];

    initial for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_erase)
            for (int i = 0; i < 256; i++) mem[{mem_addr[AW-1:8], i[7:0]}] <= 8'hFF;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_ready;
        for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        wr(a, 8'h40); wr(a, d); wait_ready();
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 ready", {7'd0, ready}, 8'h01);
        rd(12'h000, v); check("R1 array mode", v, 8'hFF);
        wr(0, 8'h70); rd(0, v); check("R1 status", v, 8'h80);
    endtask

    task automatic t_program;
        logic [7:0] v;
        wr(12'h123, 8'h40); wr(12'h123, 8'h3C);
        repeat (PC - 1) @(negedge clk);
        check("R3 busy window", {7'd0, ready}, 8'h00);
        @(negedge clk);
        check("R3 done", {7'd0, ready}, 8'h01);
        program_byte(12'h123, 8'hF0);
        wr(0, 8'hFF); rd(12'h123, v); check("R3 and", v, 8'h30);
    endtask

    task automatic t_erase;
        logic [7:0] v;
        program_byte(12'h200, 8'h00);
        wr(12'h1AB, 8'h20); wr(12'h1AB, 8'hD0);
        rd_addr = 12'h123; #1 check("R5 busy status", rd_data, 8'h00);
        repeat (EC - 1) @(negedge clk);
        check("R2 busy window", {7'd0, ready}, 8'h00);
        @(negedge clk);
        check("R2 done", {7'd0, ready}, 8'h01);
        wr(0, 8'hFF);
        rd(12'h123, v); check("R2 erased", v, 8'hFF);
        rd(12'h200, v); check("R2 other block", v, 8'h00);
    endtask

    task automatic t_invalid_sticky;
        logic [7:0] v;
        wr(12'h100, 8'h20); wr(12'h100, 8'h77);
        check("R6 no start", {7'd0, ready}, 8'h01);
        rd(0, v); check("R6 erase seq", v, 8'hB0);
        program_byte(12'h0F0, 8'h0F);
        rd(0, v); check("R7 kept after op", v, 8'hB0);
        wr(0, 8'hFF); wr(0, 8'h70); rd(0, v); check("R7 kept after mode", v, 8'hB0);
        wr(0, 8'h50); rd(0, v); check("R7 cleared", v, 8'h80);
        wr(12'h100, 8'h60); wr(12'h100, 8'h33);
        rd(0, v); check("R6 lock seq", v, 8'hB0);
        wr(0, 8'h50);
    endtask

    task automatic t_erase_suspend;
        logic [7:0] v;
        program_byte(12'h305, 8'h11);
        wr(12'h300, 8'h20); wr(12'h300, 8'hD0);
        repeat (10) @(negedge clk);
        wr(0, 8'hB0);
        check("R8 ready after susp", {7'd0, ready}, 8'h01);
        rd(0, v); check("R8 esusp status", v, 8'hC0);
        wr(0, 8'hFF); rd(12'h305, v); check("R8 not erased", v, 8'h11);
        program_byte(12'h410, 8'h5A);
        rd(0, v); check("R9 still suspended", v, 8'hC0);
        wr(12'h320, 8'h40); wr(12'h320, 8'h00);
        rd(0, v); check("R9 same block", v, 8'hF0);
        wr(0, 8'h50); wr(0, 8'hD0);
        check("R8 resumed busy", {7'd0, ready}, 8'h00);
        wait_ready();
        rd(0, v); check("R8 resume status", v, 8'h80);
        wr(0, 8'hFF);
        rd(12'h305, v); check("R8 erased", v, 8'hFF);
        rd(12'h410, v); check("R9 prog ok", v, 8'h5A);
        rd(12'h320, v); check("R9 rejected", v, 8'hFF);
    endtask

    task automatic t_nested;
        logic [7:0] v;
        program_byte(12'h505, 8'h77);
        wr(12'h500, 8'h20); wr(12'h500, 8'hD0);
        repeat (5) @(negedge clk);
        wr(0, 8'hB0);
        wr(12'h600, 8'h40); wr(12'h600, 8'h12);
        repeat (2) @(negedge clk);
        wr(0, 8'hB0);
        rd(0, v); check("R10 both susp", v, 8'hC4);
        wr(0, 8'hFF); rd(12'h505, v); check("R10 read during susp", v, 8'h77);
        wr(0, 8'hD0);
        check("R10 prog resumed", {7'd0, ready}, 8'h00);
        wait_ready();
        rd(0, v); check("R10 back to esusp", v, 8'hC0);
        wr(0, 8'hD0); wait_ready();
        rd(0, v); check("R10 all done", v, 8'h80);
        wr(0, 8'hFF);
        rd(12'h505, v); check("R10 erased", v, 8'hFF);
        rd(12'h600, v); check("R10 programmed", v, 8'h12);
    endtask

    task automatic t_last_cycle_suspend;
        logic [7:0] v;
        wr(12'h820, 8'h40); wr(12'h820, 8'h81);
        repeat (PC - 2) @(negedge clk);
        wr(0, 8'hB0);
        check("R8 final cycle ready", {7'd0, ready}, 8'h01);
        rd(0, v); check("R8 final cycle status", v, 8'h80);
        wr(0, 8'hFF); rd(12'h820, v); check("R8 final cycle data", v, 8'h81);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        wr(12'h020, 8'h40); wr(12'h020, 8'h0F);
        wr(0, 8'hFF);
        wr(12'h030, 8'h20);
        wait_ready();
        rd(12'h020, v); check("R13 mode kept", v, 8'h80);
        wr(12'h030, 8'hD0);
        rd(0, v); check("R13 setup ignored", v, 8'h80);
        wr(0, 8'hFF); rd(12'h030, v); check("R13 no erase", v, 8'hFF);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        wr(12'h700, 8'h60); wr(12'h700, 8'h01);
        wr(0, 8'h90);
        rd(12'h702, v); check("R11 lock bit", v, 8'h01);
        rd(12'h602, v); check("R4 id unlocked", v, 8'h00);
        rd(12'h000, v); check("R4 id mfg", v, 8'h5A);
        rd(12'h001, v); check("R4 id dev", v, 8'hA6);
        rd(12'h003, v); check("R4 id pad", v, 8'h00);
        wr(12'h710, 8'h40); wr(12'h710, 8'h00);
        check("R11 no busy", {7'd0, ready}, 8'h01);
        rd(0, v); check("R11 prog protect", v, 8'h82);
        wr(0, 8'h50);
        wr(12'h700, 8'h20); wr(12'h700, 8'hD0);
        rd(0, v); check("R11 erase protect", v, 8'h82);
        wr(0, 8'h50);
        wr(0, 8'hFF); rd(12'h710, v); check("R11 data kept", v, 8'hFF);
        wr(12'h000, 8'h60); wr(12'h000, 8'hD0);
        wr(0, 8'h90); rd(12'h702, v); check("R11 unlocked", v, 8'h00);
    endtask

    task automatic t_vpp;
        logic [7:0] v;
        vpp_ok = 1'b0;
        wr(12'h040, 8'h40); wr(12'h040, 8'h00);
        check("R12 no busy", {7'd0, ready}, 8'h01);
        rd(0, v); check("R12 status", v, 8'h88);
        vpp_ok = 1'b1;
        wr(0, 8'h50); wr(0, 8'hFF);
        rd(12'h040, v); check("R12 data kept", v, 8'hFF);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_erase();
        t_invalid_sticky();
        t_erase_suspend();
        t_nested();
        t_last_cycle_suspend();
        t_busy_ignore();
        t_lock();
        t_vpp();
        report();
    end
endmodule